// File: doc/BRIEF.md
# Audio Playback Control Register Bank

This block is a byte-wide register file placed between a host bus and two audio neighbours: a codec that accepts packed control commands, and an output DMA engine that streams a playback buffer. The host writes three staging bytes for the codec. After any staging write, the block sends one command to the codec, but only when the top two bits of staging byte 0 carry the valid tag. The block also holds a 16-bit playback buffer size that is kept four-byte aligned, and an output control byte. Bit 0 of the control byte enables playback.

A write that sets the enable bit produces a one-cycle start pulse to the DMA engine. The pulse comes with an aligned base address, the current buffer length and a sample-rate code. A write that clears the enable bit produces a one-cycle stop pulse. For reads, the block shows three bytes of codec status and a 24-bit playback phase word, one byte per address. The phase word packs the DMA engine's buffer offset above a prescale field that always reads as zero.

Top module: `audio_dma_regbank`

## Requirements
- R1: After reset, every stored byte reads as zero, `rdata` is zero, and `cmd_stb`, `dma_start` and `dma_stop` are low.
- R2: A write to a staging address (0x0, 0x1 or 0x2) stores that byte. In the cycle after the write edge, `cmd_stb` is high for exactly one cycle if and only if bits [7:6] of staging byte 0, after the write, equal the tag `2'b10`.
- R3: With a strobe, `cmd_addr` equals staging byte 0 bits [5:0] bitwise-ORed with staging byte 1 bits [7:4], zero-extended to six bits. `cmd_data` is {staging byte 1 bits [3:0], staging byte 2}.
- R4: Address 0x8 writes the high byte and address 0x9 writes the low byte of the buffer size; each write leaves the other byte unchanged. Size bits [1:0] always read as zero. Both addresses read back the stored byte.
- R5: Address 0xA stores the full written control byte on every write and reads it back unchanged.
- R6: A control write that changes bit 0 from 0 to 1 gives a one-cycle `dma_start`. In the same cycle, `dma_base_out` is `dma_base_in` with bits [17:0] cleared, `dma_len` is the stored buffer size, and `dma_rate` is bits [2:1] of the written byte.
- R7: A control write that changes bit 0 from 1 to 0 gives a one-cycle `dma_stop`. A control write that leaves bit 0 unchanged gives neither pulse.
- R8: The phase word is {6'b0, `dma_pos`[11:0], 6'b0}. Addresses 0xC, 0xD and 0xE return its bits [23:16], [15:8] and [7:0].
- R9: Addresses 0x4, 0x5 and 0x6 return `codec_stat` bits [7:0], [15:8] and [23:16].
- R10: `rdata` takes the addressed value one cycle after `rd_en` and holds while `rd_en` is low. Staging addresses and unused addresses (0x3, 0x7, 0xB, 0xF) read zero. Writes to read-only or unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| codec_stat | input | 24 | Codec status word |
| cmd_stb | output | 1 | Codec command strobe |
| cmd_addr | output | 6 | Codec command address |
| cmd_data | output | 12 | Codec command data |
| dma_base_in | input | 32 | DMA base address from the system |
| dma_pos | input | 12 | Current DMA buffer offset |
| dma_start | output | 1 | Playback start pulse |
| dma_stop | output | 1 | Playback stop pulse |
| dma_base_out | output | 32 | Aligned buffer base given at start |
| dma_len | output | 16 | Buffer length given at start |
| dma_rate | output | 2 | Sample-rate code given at start |

## Verification
A wrong stored enable bit appears within one cycle: a missing or extra start or stop pulse follows the next control write. A corrupted staging byte appears in the command fields on the next tagged strobe. A size register that keeps its low bits, or that overwrites the neighbouring byte, appears in the next size readback and in the length given at the next start. Read-path errors show one cycle after `rd_en`, because every readable byte is compared with a model built from the inputs that the bench itself drives.

// File: rtl/audio_regs_pkg.sv
package audio_regs_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_STG0 = 4'h0,
    RA_STG1 = 4'h1,
    RA_STG2 = 4'h2,
    RA_STS0 = 4'h4,
    RA_STS1 = 4'h5,
    RA_STS2 = 4'h6,
    RA_SZHI = 4'h8,
    RA_SZLO = 4'h9,
    RA_OCTL = 4'hA,
    RA_PHS0 = 4'hC,
    RA_PHS1 = 4'hD,
    RA_PHS2 = 4'hE
  } reg_addr_e;
endpackage

// File: rtl/codec_stage.sv
module codec_stage
  import audio_regs_pkg::*;
#(
  parameter logic [1:0] TAG = 2'b10,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              cmd_stb,
  output logic [5:0]        cmd_addr,
  output logic [11:0]       cmd_data
);
  logic [BYTE_W-1:0] stg_q [STAGES];
  logic [BYTE_W-1:0] stg_n [STAGES];
  logic hit;
  logic tag_ok;

  assign hit = wr_en && (int'(addr) < STAGES);

  // next value of each staging byte, so the command uses post-write data
  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      stg_n[i] = (wr_en && (int'(addr) == i)) ? wdata : stg_q[i];
    end
  end

  assign tag_ok = (stg_n[0][7:6] == TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      cmd_stb  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_n[i];
      cmd_stb <= hit && tag_ok;
      if (hit && tag_ok) begin
        cmd_addr <= stg_n[0][5:0] | {2'b00, stg_n[1][7:4]};
        cmd_data <= {stg_n[1][3:0], stg_n[2]};
      end
    end
  end

  // R2: a strobe only follows a write edge
  a_r2_after_write: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> $past(wr_en));
  // R2: a strobe only with the valid tag held in staging byte 0
  a_r2_tag_held: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> (stg_q[0][7:6] == TAG));
  // R3: command data low byte matches staging byte 2 at strobe
  a_r3_data_low: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> (cmd_data[7:0] == stg_q[2]));
endmodule

// File: rtl/playback_ctl.sv
module playback_ctl
  import audio_regs_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int BASE_W   = 32,
  parameter int BASE_CLR = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BASE_W-1:0] dma_base_in,
  output logic [LEN_W-1:0]  size_q,
  output logic [BYTE_W-1:0] ctl_q,
  output logic              dma_start,
  output logic              dma_stop,
  output logic [BASE_W-1:0] dma_base_out,
  output logic [LEN_W-1:0]  dma_len,
  output logic [1:0]        dma_rate
);
  localparam int HI_W = LEN_W - BYTE_W;

  logic wr_hi, wr_lo, wr_ctl, rise, fall;

  assign wr_hi  = wr_en && (addr == RA_SZHI);
  assign wr_lo  = wr_en && (addr == RA_SZLO);
  assign wr_ctl = wr_en && (addr == RA_OCTL);
  assign rise   = wr_ctl &&  wdata[0] && !ctl_q[0];
  assign fall   = wr_ctl && !wdata[0] &&  ctl_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
    end else if (wr_hi) begin
      size_q <= {wdata[HI_W-1:0], size_q[BYTE_W-1:2], 2'b00};
    end else if (wr_lo) begin
      size_q <= {size_q[LEN_W-1:BYTE_W], wdata[BYTE_W-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= '0;
      dma_start    <= 1'b0;
      dma_stop     <= 1'b0;
      dma_base_out <= '0;
      dma_len      <= '0;
      dma_rate     <= '0;
    end else begin
      dma_start <= rise;
      dma_stop  <= fall;
      if (wr_ctl) ctl_q <= wdata;
      if (rise) begin
        dma_base_out <= {dma_base_in[BASE_W-1:BASE_CLR], {BASE_CLR{1'b0}}};
        dma_len      <= size_q;
        dma_rate     <= wdata[2:1];
      end
    end
  end

  // R6: start leaves the enable set
  a_r6_start_enabled: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> ctl_q[0]);
  // R7: stop leaves the enable clear
  a_r7_stop_disabled: assert property (@(posedge clk) disable iff (rst)
    dma_stop |-> !ctl_q[0]);
  // R7: no pulse without an enable change
  a_r7_needs_change: assert property (@(posedge clk) disable iff (rst)
    (dma_start || dma_stop) |-> (ctl_q[0] != $past(ctl_q[0])));
  // R6: start and stop never together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dma_start && dma_stop));
  // R4: size alignment kept
  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    (wr_hi || wr_lo) |=> (size_q[1:0] == 2'b00));
endmodule

// File: rtl/read_mux.sv
module read_mux
  import audio_regs_pkg::*;
#(
  parameter int POS_W = 12,
  parameter int PRE_W = 6,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [23:0]       codec_stat,
  input  logic [POS_W-1:0]  dma_pos,
  input  logic [LEN_W-1:0]  size_q,
  input  logic [BYTE_W-1:0] ctl_q,
  output logic [BYTE_W-1:0] rdata
);
  localparam int PH_W = 3 * BYTE_W;
  localparam int PAD  = PH_W - POS_W - PRE_W;

  logic [PH_W-1:0]   phase;
  logic [BYTE_W-1:0] sel;

  assign phase = {{PAD{1'b0}}, dma_pos, {PRE_W{1'b0}}};

  always_comb begin
    case (addr)
      RA_STS0: sel = codec_stat[7:0];
      RA_STS1: sel = codec_stat[15:8];
      RA_STS2: sel = codec_stat[23:16];
      RA_SZHI: sel = size_q[LEN_W-1:BYTE_W];
      RA_SZLO: sel = size_q[BYTE_W-1:0];
      RA_OCTL: sel = ctl_q;
      RA_PHS0: sel = phase[23:16];
      RA_PHS1: sel = phase[15:8];
      RA_PHS2: sel = phase[7:0];
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  // R10: read data holds without a read
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));
endmodule

// File: rtl/audio_dma_regbank.sv
module audio_dma_regbank
  import audio_regs_pkg::*;
#(
  parameter logic [1:0] TAG = 2'b10,
  parameter int POS_W    = 12,
  parameter int PRE_W    = 6,
  parameter int LEN_W    = 16,
  parameter int BASE_W   = 32,
  parameter int BASE_CLR = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [23:0]       codec_stat,
  output logic              cmd_stb,
  output logic [5:0]        cmd_addr,
  output logic [11:0]       cmd_data,
  input  logic [BASE_W-1:0] dma_base_in,
  input  logic [POS_W-1:0]  dma_pos,
  output logic              dma_start,
  output logic              dma_stop,
  output logic [BASE_W-1:0] dma_base_out,
  output logic [LEN_W-1:0]  dma_len,
  output logic [1:0]        dma_rate
);
  logic [LEN_W-1:0]  size_q;
  logic [BYTE_W-1:0] ctl_q;

  codec_stage #(.TAG(TAG), .STAGES(3)) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  playback_ctl #(.LEN_W(LEN_W), .BASE_W(BASE_W), .BASE_CLR(BASE_CLR)) u_play (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dma_base_in(dma_base_in), .size_q(size_q), .ctl_q(ctl_q),
    .dma_start(dma_start), .dma_stop(dma_stop), .dma_base_out(dma_base_out),
    .dma_len(dma_len), .dma_rate(dma_rate)
  );

  read_mux #(.POS_W(POS_W), .PRE_W(PRE_W), .LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .codec_stat(codec_stat), .dma_pos(dma_pos), .size_q(size_q),
    .ctl_q(ctl_q), .rdata(rdata)
  );

  // R1: no pulse in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !(cmd_stb || dma_start || dma_stop));
endmodule

// File: tb/audio_dma_regbank_bench.sv
module audio_dma_regbank_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [23:0] codec_stat = 0;
  logic cmd_stb, dma_start, dma_stop;
  logic [5:0] cmd_addr;
  logic [11:0] cmd_data;
  logic [31:0] dma_base_in = 0, dma_base_out;
  logic [11:0] dma_pos = 0;
  logic [15:0] dma_len;
  logic [1:0] dma_rate;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_stg [3];
  logic [15:0] m_size = 0;
  logic [7:0] m_ctl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_dma_regbank u_audio_dma_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .codec_stat(codec_stat), .cmd_stb(cmd_stb),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .dma_base_in(dma_base_in),
    .dma_pos(dma_pos), .dma_start(dma_start), .dma_stop(dma_stop),
    .dma_base_out(dma_base_out), .dma_len(dma_len), .dma_rate(dma_rate)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [23:0] ph;
    ph = {6'b0, dma_pos, 6'b0};
    case (a)
      4'h4: return codec_stat[7:0];
      4'h5: return codec_stat[15:8];
      4'h6: return codec_stat[23:16];
      4'h8: return m_size[15:8];
      4'h9: return m_size[7:0];
      4'hA: return m_ctl;
      4'hC: return ph[23:16];
      4'hD: return ph[15:8];
      4'hE: return ph[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic e_stb, e_start, e_stop;
    logic [5:0] e_ca;
    logic [11:0] e_cd;
    logic [31:0] e_base;
    logic [15:0] e_len;
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    dma_base_in = $urandom;
    e_stb = 0; e_start = 0; e_stop = 0; e_ca = 0; e_cd = 0;
    e_base = {dma_base_in[31:18], 18'b0};
    e_len = m_size;
    if (a < 3) begin
      m_stg[a] = d;
      e_stb = (m_stg[0][7:6] == 2'b10);
      e_ca = m_stg[0][5:0] | {2'b00, m_stg[1][7:4]};
      e_cd = {m_stg[1][3:0], m_stg[2]};
    end else if (a == 4'h8) begin
      m_size = {d, m_size[7:2], 2'b00};
    end else if (a == 4'h9) begin
      m_size = {m_size[15:8], d[7:2], 2'b00};
    end else if (a == 4'hA) begin
      e_start = d[0] && !m_ctl[0];
      e_stop  = !d[0] && m_ctl[0];
      m_ctl = d;
    end
    @(posedge clk); #1;
    wr_en = 0;
    chk("R2 strobe", cmd_stb, e_stb);
    if (e_stb) begin
      chk("R3 cmd_addr", cmd_addr, e_ca);
      chk("R3 cmd_data", cmd_data, e_cd);
    end
    chk("R6 start", dma_start, e_start);
    chk("R7 stop", dma_stop, e_stop);
    if (e_start) begin
      chk("R6 base", dma_base_out, e_base);
      chk("R6 len", dma_len, e_len);
      chk("R6 rate", dma_rate, d[2:1]);
    end
    @(posedge clk); #1;
    chk("R2 one-cycle strobe", {cmd_stb, dma_start, dma_stop}, 3'b000);
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    codec_stat = $urandom; dma_pos = $urandom;
    rd_en = 1; addr = a;
    e = exp_rd(a);
    @(posedge clk); #1;
    rd_en = 0;
    chk(req, rdata, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] held;
    for (int i = 0; i < 3; i++) m_stg[i] = 0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pulses", {cmd_stb, dma_start, dma_stop}, 3'b000);
    chk("R1 rdata", rdata, 8'h00);
    @(negedge clk); rst = 0;
    rd(4'h8, "R1 size hi reset"); rd(4'h9, "R1 size lo reset"); rd(4'hA, "R1 ctl reset");

    // directed: staging without then with tag
    wr(4'h1, 8'hA5); wr(4'h2, 8'h3C);
    wr(4'h0, 8'h41);           // tag 01: no strobe
    wr(4'h0, 8'h8B);           // tag 10: strobe
    wr(4'h2, 8'hF0);           // strobe again with new data
    wr(4'h0, 8'hC0);           // tag 11: none
    // size alignment and byte independence
    wr(4'h8, 8'h12); wr(4'h9, 8'hFF);
    rd(4'h9, "R4 low bits cleared"); rd(4'h8, "R4 high kept");
    wr(4'h8, 8'hAB); rd(4'h9, "R4 low untouched");
    // control: start, no-change, stop
    wr(4'hA, 8'h05); rd(4'hA, "R5 readback");
    wr(4'hA, 8'hF7); rd(4'hA, "R5 full byte stored");
    wr(4'hA, 8'h02); wr(4'hA, 8'h00);
    // ignored writes
    wr(4'h4, 8'hFF); wr(4'hC, 8'hFF); wr(4'h3, 8'hFF); wr(4'hF, 8'hFF);
    rd(4'h8, "R10 size after ignored"); rd(4'hA, "R10 ctl after ignored");
    rd(4'h3, "R10 unused zero"); rd(4'h1, "R10 staging reads zero");
    // phase and status
    rd(4'hC, "R8 phase hi"); rd(4'hD, "R8 phase mid"); rd(4'hE, "R8 phase lo");
    rd(4'h4, "R9 status 0"); rd(4'h5, "R9 status 1"); rd(4'h6, "R9 status 2");
    // hold without read
    rd(4'hA, "R10 read");
    held = rdata;
    @(negedge clk); addr = 4'h4; codec_stat = 24'h123456;
    @(posedge clk); #1;
    chk("R10 hold", rdata, held);

    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      if (a == 0 && $urandom_range(0, 1) == 1) d[7:6] = 2'b10;
      if ($urandom_range(0, 1) == 1) wr(a, d);
      else rd(a, "R10 random read");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule